// File: doc/BRIEF.md
# Region-Based Bus Address Decoder

This block sits between a single CPU bus master and a set of peripheral slaves. It works at the level of whole peripherals, not individual registers. Each slave owns one contiguous address region, and the block raises one enable line for that slave when the CPU presents an address inside its region. It also steers that slave's read-data bus back to the CPU. The slave sees the full address and decodes the low bits itself to pick its internal register. Unused addresses inside a region are simply wasted, which keeps the interconnect small.

Every region size is a power of two, and every base is a multiple of its own size. A region hit is therefore a masked equality test on the address bits above the region size, with no range comparators. The region table is a pair of parameters. Elaboration stops with an error if a size is not a power of two, if a base is misaligned, or if two regions overlap. The decode is purely combinational: outputs follow the address in the same cycle. An address that falls in no region raises a decode-error flag instead of an enable.

Top module: `bus_region_decoder`

## Requirements
- R1: While `cpu_valid` is high, `slv_en[i]` is high exactly when `cpu_addr` lies between `REGION_BASE[i]` and `REGION_BASE[i] + REGION_SIZE[i] - 1`, both ends included; the test uses only the address bits at or above log2 of the region size.
- R2: `slv_en` is always one-hot or all zero.
- R3: While `cpu_valid` is low, `slv_en` is all zero, `dec_err` is low and `cpu_rdata` is zero, whatever the address.
- R4: While `cpu_valid` is high and the address lies in no region, `dec_err` is high, `slv_en` is all zero and `cpu_rdata` is zero.
- R5: When `slv_en[i]` is high, `cpu_rdata` equals slave i's read word, `slv_rdata[i*DW +: DW]`; the read data of other slaves has no effect.
- R6: With default parameters there are eight 512 MB regions, and slave k owns `k*0x2000_0000` to `k*0x2000_0000 + 0x1FFF_FFFF`, so `cpu_addr[31:29]` picks the slave; address `0x0085_6840` enables only slave 0.
- R7: The first and last byte address of every region select that region. The address just past the last byte, and the address just before the first byte, do not select it.
- R8: All outputs are combinational functions of the current inputs: a new address or valid value is reflected within the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_valid | input | 1 | CPU access strobe; gates all enables and the error flag |
| cpu_addr | input | AW | CPU byte address |
| cpu_rdata | output | DW | Read word returned to the CPU (zero when no slave is enabled) |
| dec_err | output | 1 | High when a valid access hits no region |
| slv_en | output | N_SLV | One enable per slave region |
| slv_rdata | input | N_SLV*DW | Read words of all slaves, slave i at bits `[i*DW +: DW]` |

## Verification
The bench builds two instances. The first uses the default eight evenly split regions with the AND-OR return path. It covers the top-bit selection, the fixed example address and every region edge across a dense map. The second has four sparse regions from 4 KB to 16 MB, one of them ending at the top of the address space, and uses the indexed return path. It reaches unmapped holes between regions, addresses one byte outside each edge, and the wraparound past the highest address. This puts both return-path variants and the decode-error path under the same random and directed stimulus.

// File: rtl/bdec_pkg.sv
`timescale 1ns/1ps
package bdec_pkg;

   // Wide enough for any address width this decoder is built with.
   localparam int unsigned CFG_W = 64;
   typedef logic [CFG_W-1:0] cfg_word_t;

   // Read-data return path variants.
   typedef enum logic [0:0] {
      MUX_AND_OR  = 1'b0,
      MUX_INDEXED = 1'b1
   } mux_style_e;

   // Exactly one bit set.
   function automatic bit is_pow2(cfg_word_t v);
      return (v != '0) && ((v & (v - 1'b1)) == '0);
   endfunction

   // Base is a whole multiple of the size.
   function automatic bit is_aligned(cfg_word_t base, cfg_word_t size);
      return (base & (size - 1'b1)) == '0;
   endfunction

   // Two aligned power-of-two regions intersect exactly when they agree on
   // every bit above the larger of the two sizes.
   function automatic bit regions_overlap(cfg_word_t b0, cfg_word_t s0,
                                          cfg_word_t b1, cfg_word_t s1);
      cfg_word_t big;
      big = (s0 > s1) ? s0 : s1;
      return (b0 & ~(big - 1'b1)) == (b1 & ~(big - 1'b1));
   endfunction

endpackage

// File: rtl/bdec_region_match.sv
`timescale 1ns/1ps
module bdec_region_match #(
   parameter int unsigned    AW   = 32,
   parameter logic [AW-1:0] BASE = '0,
   parameter logic [AW-1:0] SIZE = AW'(1) << (AW - 1)
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   // Bits below the region size are the slave's own offset and are dropped.
   localparam logic [AW-1:0] KEEP_MASK = ~(SIZE - AW'(1));

   assign hit = ((addr & KEEP_MASK) == BASE);
endmodule

// File: rtl/bdec_select.sv
`timescale 1ns/1ps
module bdec_select #(
   parameter int unsigned N_SLV = 8,
   parameter int unsigned IW    = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
   input  logic             valid,
   input  logic [N_SLV-1:0] hit,
   output logic [N_SLV-1:0] en,
   output logic [IW-1:0]    idx,
   output logic             err
);
   logic any_hit;

   assign any_hit = |hit;
   assign en      = valid ? hit : '0;
   assign err     = valid & ~any_hit;

   // Regions never overlap, so at most one hit bit is set.
   always_comb begin
      idx = '0;
      for (int i = 0; i < N_SLV; i++) begin
         if (hit[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/bdec_rdata_mux.sv
`timescale 1ns/1ps
module bdec_rdata_mux #(
   parameter int unsigned          N_SLV = 8,
   parameter int unsigned          DW    = 32,
   parameter int unsigned          IW    = (N_SLV > 1) ? $clog2(N_SLV) : 1,
   parameter bdec_pkg::mux_style_e STYLE = bdec_pkg::MUX_AND_OR
) (
   input  logic [N_SLV-1:0]    en,
   input  logic [IW-1:0]       idx,
   input  logic [N_SLV*DW-1:0] rdata_in,
   output logic [DW-1:0]       rdata_out
);
   logic [DW-1:0] words [N_SLV];

   for (genvar gi = 0; gi < N_SLV; gi++) begin : g_split
      assign words[gi] = rdata_in[gi*DW +: DW];
   end

   if (STYLE == bdec_pkg::MUX_AND_OR) begin : g_and_or
      // Flat OR of enable-qualified words; relies on one-hot enables.
      always_comb begin
         rdata_out = '0;
         for (int i = 0; i < N_SLV; i++) begin
            rdata_out = rdata_out | (words[i] & {DW{en[i]}});
         end
      end
   end else begin : g_indexed
      // Binary-indexed mux, zero forced when nothing is enabled.
      logic any_en;
      assign any_en    = |en;
      assign rdata_out = any_en ? words[idx] : '0;
   end
endmodule

// File: rtl/bus_region_decoder.sv
`timescale 1ns/1ps
module bus_region_decoder #(
   parameter int unsigned N_SLV = 8,
   parameter int unsigned AW    = 32,
   parameter int unsigned DW    = 32,
   parameter logic [N_SLV-1:0][AW-1:0] REGION_BASE = {
      32'hE000_0000, 32'hC000_0000, 32'hA000_0000, 32'h8000_0000,
      32'h6000_0000, 32'h4000_0000, 32'h2000_0000, 32'h0000_0000},
   parameter logic [N_SLV-1:0][AW-1:0] REGION_SIZE = {N_SLV{32'h2000_0000}},
   parameter bdec_pkg::mux_style_e MUX_STYLE = bdec_pkg::MUX_AND_OR
) (
   input  logic                cpu_valid,
   input  logic [AW-1:0]       cpu_addr,
   output logic [DW-1:0]       cpu_rdata,
   output logic                dec_err,
   output logic [N_SLV-1:0]    slv_en,
   input  logic [N_SLV*DW-1:0] slv_rdata
);
   import bdec_pkg::*;

   localparam int unsigned IW = (N_SLV > 1) ? $clog2(N_SLV) : 1;

   // Elaboration-time checks on the region table.
   if (N_SLV < 1) begin : g_bad_count
      $error("bus_region_decoder: N_SLV must be at least 1");
   end
   if (AW > CFG_W) begin : g_bad_aw
      $error("bus_region_decoder: AW exceeds supported configuration width");
   end

   for (genvar gi = 0; gi < N_SLV; gi++) begin : g_cfg
      if (!is_pow2(CFG_W'(REGION_SIZE[gi]))) begin : g_bad_size
         $error("bus_region_decoder: region %0d size is not a power of two", gi);
      end
      if (!is_aligned(CFG_W'(REGION_BASE[gi]), CFG_W'(REGION_SIZE[gi]))) begin : g_bad_base
         $error("bus_region_decoder: region %0d base is not aligned to its size", gi);
      end
      for (genvar gj = gi + 1; gj < N_SLV; gj++) begin : g_pair
         if (regions_overlap(CFG_W'(REGION_BASE[gi]), CFG_W'(REGION_SIZE[gi]),
                             CFG_W'(REGION_BASE[gj]), CFG_W'(REGION_SIZE[gj]))) begin : g_bad_ovl
            $error("bus_region_decoder: regions %0d and %0d overlap", gi, gj);
         end
      end
   end

   // One masked comparator per region.
   logic [N_SLV-1:0] hit;

   for (genvar gi = 0; gi < N_SLV; gi++) begin : g_match
      bdec_region_match #(
         .AW   (AW),
         .BASE (REGION_BASE[gi]),
         .SIZE (REGION_SIZE[gi])
      ) u_match (
         .addr (cpu_addr),
         .hit  (hit[gi])
      );
   end

   logic [IW-1:0] sel_idx;

   bdec_select #(
      .N_SLV (N_SLV),
      .IW    (IW)
   ) u_select (
      .valid (cpu_valid),
      .hit   (hit),
      .en    (slv_en),
      .idx   (sel_idx),
      .err   (dec_err)
   );

   bdec_rdata_mux #(
      .N_SLV (N_SLV),
      .DW    (DW),
      .IW    (IW),
      .STYLE (MUX_STYLE)
   ) u_rmux (
      .en        (slv_en),
      .idx       (sel_idx),
      .rdata_in  (slv_rdata),
      .rdata_out (cpu_rdata)
   );
endmodule

// File: rtl/bdec_chk.sv
`timescale 1ns/1ps
module bdec_chk #(
   parameter int unsigned N_SLV = 8,
   parameter int unsigned DW    = 32
) (
   input logic                cpu_valid,
   input logic [DW-1:0]       cpu_rdata,
   input logic                dec_err,
   input logic [N_SLV-1:0]    slv_en,
   input logic [N_SLV*DW-1:0] slv_rdata
);
   logic [DW-1:0] picked;

   always_comb begin
      picked = '0;
      for (int i = 0; i < N_SLV; i++) begin
         if (slv_en[i]) picked = slv_rdata[i*DW +: DW];
      end
   end

   always_comb begin
      // R2
      onehot_en_chk: assert ($onehot0(slv_en))
         else $error("enables not one-hot: %b", slv_en);
      // R3
      idle_quiet_chk: assert (cpu_valid || (slv_en == '0 && !dec_err))
         else $error("activity while bus idle");
      // R4
      err_excl_chk: assert (!dec_err || (slv_en == '0 && cpu_rdata == '0))
         else $error("decode error with enable or nonzero data");
      // R1
      hit_or_err_chk: assert (!cpu_valid || ((|slv_en) != dec_err))
         else $error("valid access neither hit nor flagged");
      // R5
      rdata_route_chk: assert ((slv_en == '0) || (cpu_rdata == picked))
         else $error("read data not from enabled slave");
   end
endmodule

bind bus_region_decoder bdec_chk #(
   .N_SLV (N_SLV),
   .DW    (DW)
) u_bdec_chk (
   .cpu_valid (cpu_valid),
   .cpu_rdata (cpu_rdata),
   .dec_err   (dec_err),
   .slv_en    (slv_en),
   .slv_rdata (slv_rdata)
);

// File: tb/tb_bus_region_decoder.sv
`timescale 1ns/1ps
module tb_bus_region_decoder;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int ND = 8;
   localparam int NS = 4;

   localparam logic [NS-1:0][AW-1:0] SP_BASE = {
      32'hFFFF_F000, 32'h8001_0000, 32'h4000_0000, 32'h0000_0000};
   localparam logic [NS-1:0][AW-1:0] SP_SIZE = {
      32'h0000_1000, 32'h0001_0000, 32'h0100_0000, 32'h0000_1000};

   // Bench-side range table: inclusive low and high byte addresses.
   logic [31:0] sp_lo [NS] = '{32'h0000_0000, 32'h4000_0000, 32'h8001_0000, 32'hFFFF_F000};
   logic [31:0] sp_hi [NS] = '{32'h0000_0FFF, 32'h40FF_FFFF, 32'h8001_FFFF, 32'hFFFF_FFFF};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic valid = 1'b0;
   logic [AW-1:0] addr_d = '0;
   logic [AW-1:0] addr_s = '0;
   logic [ND*DW-1:0] rd_d = '0;
   logic [NS*DW-1:0] rd_s = '0;

   logic [DW-1:0] out_d, out_s;
   logic err_d, err_s;
   logic [ND-1:0] en_d;
   logic [NS-1:0] en_s;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   bus_region_decoder #(
      .N_SLV (ND), .AW (AW), .DW (DW),
      .MUX_STYLE (bdec_pkg::MUX_AND_OR)
   ) dut (
      .cpu_valid (valid), .cpu_addr (addr_d), .cpu_rdata (out_d),
      .dec_err (err_d), .slv_en (en_d), .slv_rdata (rd_d)
   );

   bus_region_decoder #(
      .N_SLV (NS), .AW (AW), .DW (DW),
      .REGION_BASE (SP_BASE), .REGION_SIZE (SP_SIZE),
      .MUX_STYLE (bdec_pkg::MUX_INDEXED)
   ) dut_sparse (
      .cpu_valid (valid), .cpu_addr (addr_s), .cpu_rdata (out_s),
      .dec_err (err_s), .slv_en (en_s), .slv_rdata (rd_s)
   );

   function automatic int exp_dense(logic [31:0] a);
      return int'(a[31:29]);
   endfunction

   function automatic int exp_sparse(logic [31:0] a);
      int r = -1;
      for (int k = 0; k < NS; k++) begin
         if (a >= sp_lo[k] && a <= sp_hi[k]) r = k;
      end
      return r;
   endfunction

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      int ed, es;
      logic [ND-1:0] xen_d;
      logic [NS-1:0] xen_s;
      logic [DW-1:0] xr_d, xr_s;
      ed = valid ? exp_dense(addr_d) : -1;
      es = valid ? exp_sparse(addr_s) : -1;
      xen_d = (ed >= 0) ? ND'(1) << ed : '0;
      xen_s = (es >= 0) ? NS'(1) << es : '0;
      xr_d  = (ed >= 0) ? rd_d[ed*DW +: DW] : '0;
      xr_s  = (es >= 0) ? rd_s[es*DW +: DW] : '0;
      check(en_d == xen_d, tag, "dense enables", 64'(en_d), 64'(xen_d));
      check(en_s == xen_s, tag, "sparse enables", 64'(en_s), 64'(xen_s));
      check(err_d == (valid && ed < 0), {"R4 ", tag}, "dense dec_err", 64'(err_d), 64'(valid && ed < 0));
      check(err_s == (valid && es < 0), {"R4 ", tag}, "sparse dec_err", 64'(err_s), 64'(valid && es < 0));
      check(out_d == xr_d, {"R5 ", tag}, "dense rdata", 64'(out_d), 64'(xr_d));
      check(out_s == xr_s, {"R5 ", tag}, "sparse rdata", 64'(out_s), 64'(xr_s));
      check($onehot0(en_d) && $onehot0(en_s), {"R2 ", tag}, "one-hot", 64'({en_s, en_d}), 64'(0));
   endtask

   task automatic apply(bit v, logic [31:0] ad, logic [31:0] as, string tag);
      @(posedge clk);
      valid  = v;
      addr_d = ad;
      addr_s = as;
      for (int i = 0; i < ND; i++) rd_d[i*DW +: DW] = $urandom;
      for (int i = 0; i < NS; i++) rd_s[i*DW +: DW] = $urandom;
      @(negedge clk);
      check_all(tag);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R3: reset state, bus idle
      check_all("R3 reset");
      rst_n = 1'b1;

      // R6: fixed example address lands in slave 0 only
      apply(1'b1, 32'h0085_6840, 32'h0000_0840, "R6 example");
      check(en_d == 8'h01, "R6", "example enable", 64'(en_d), 64'h01);

      // R7: first and last byte of every dense region
      for (int k = 0; k < ND; k++) begin
         apply(1'b1, 32'(k) << 29, sp_lo[k % NS], "R7 first");
         apply(1'b1, (32'(k) << 29) | 32'h1FFF_FFFF, sp_hi[k % NS], "R7 last");
      end
      // R7: just outside each sparse region edge (wraps at the top)
      for (int k = 0; k < NS; k++) begin
         apply(1'b1, $urandom, sp_hi[k] + 32'd1, "R7 past end");
         if (sp_lo[k] != 0) apply(1'b1, $urandom, sp_lo[k] - 32'd1, "R7 before start");
      end

      // R4: unmapped holes in the sparse map
      apply(1'b1, 32'h2000_0000, 32'h2000_0000, "R4 hole");
      apply(1'b1, 32'h0000_1000, 32'h0000_1000, "R4 hole");
      apply(1'b1, 32'h8000_FFFF, 32'h8002_0000, "R4 hole");

      // R3: idle bus with mapped addresses
      apply(1'b0, 32'h0085_6840, 32'h4000_0010, "R3 idle");
      apply(1'b0, 32'hFFFF_FFFF, 32'hFFFF_F004, "R3 idle");

      // R8: back-to-back address changes seen in the same cycle
      apply(1'b1, 32'h6000_0000, 32'h4012_3456, "R8 step");
      apply(1'b1, 32'hA000_0004, 32'h8001_0010, "R8 step");
      apply(1'b1, 32'h1FFF_FFFC, 32'h7000_0000, "R8 step");

      // R1 R5: random mix, some aimed near sparse regions
      for (int n = 0; n < 400; n++) begin
         logic [31:0] as;
         int pick;
         pick = int'($urandom_range(0, 4));
         if (pick < NS) as = sp_lo[pick] + ($urandom & (sp_hi[pick] - sp_lo[pick]))
                             + ((($urandom & 7) == 0) ? 32'h0001_0000 : 32'h0);
         else           as = $urandom;
         apply(($urandom & 3) != 0, $urandom, as, "R1 random");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R8 actual=timeout expected=completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule